// File: doc/BRIEF.md
# Multi-Lane Marker Deskew

This block takes parallel words from several serial lanes. Each word comes with a valid flag and a flag that says an alignment marker was found in it. Every lane writes into its own small FIFO. While alignment is being acquired, a lane throws away words until a marker reaches the head of its FIFO. It then holds there, and all lanes start reading together once every head shows a marker. From then on, the words that leave the block on one cycle come from the same stream position on every lane.

A four-state controller (idle, waiting, aligned, error) follows the alignment state.
- Once aligned, it checks every forwarded word. A word in which some lanes carry a marker and others do not counts as a misalignment.
- A build-time option decides what happens next. With auto-realignment, the block drops back to idle and acquires again on its own. Without it, the block latches an error state until the user asserts the relink request.
- A relink request, a lane that is not ready, or a FIFO overflow forces the block back to idle and empties all FIFOs.

Top module: `lane_deskew`

## Requirements
- R1: After reset, `aligned`, `err` and `out_vld` are low.
- R2: The block leaves idle only on a cycle where every bit of `lane_rdy` is high and `relink` is low. While `relink` is held high, or any lane is not ready, `aligned` never rises, even with markers arriving.
- R3: Lane skew may be anywhere from 0 to DEPTH-2 cycles. Under any such skew the block reaches `aligned`, and the first word it forwards is the marker word on every lane. Lane i's word sits in `out_data[i*DW +: DW]`, and all lanes in one output cycle carry the same stream position.
- R4: Once aligned, with every lane delivering continuously, words leave one per cycle in arrival order, with no gap, drop or repeat.
- R5: `out_vld` is high only while `aligned` is high.
- R6: With AUTO_REALIGN=1, a forwarded word where at least one lane's marker (`in_mark[i]`) is set and another's is not drops `aligned`. `err` stays low, and the block acquires again at the next common marker without any relink.
- R7: With AUTO_REALIGN=0, the same event raises `err` and drops `aligned` and `out_vld`. The error state holds until `relink` is asserted, after which alignment is acquired again.
- R8: In any state, `relink` high or any `lane_rdy` bit low makes `aligned` and `out_vld` low one cycle later. All FIFOs are emptied, so no word buffered before the event is forwarded afterwards.
- R9: A write into a full lane FIFO (for example, one lane stops delivering while aligned) returns the block to idle and drops `aligned`. `err` stays low whatever AUTO_REALIGN is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | LANES*DW | Lane words; lane i in bits [i*DW +: DW] |
| in_vld | input | LANES | Per-lane word valid |
| in_mark | input | LANES | Per-lane marker flag for the current word |
| lane_rdy | input | LANES | Per-lane ready from the receive logic |
| relink | input | 1 | User request to restart alignment |
| out_data | output | LANES*DW | Aligned lane words, same layout as in_data |
| out_vld | output | 1 | Aligned output word valid |
| aligned | output | 1 | High while the lanes are aligned |
| err | output | 1 | High in the latched error state |

## Verification
The main test sweeps every combination of skews from 0 to 6 cycles over three lanes.
- Each word on each lane encodes its lane index and its stream position. A forwarded cycle that mixes positions across lanes, skips a position, or does not start at a marker is therefore caught directly.
- A single marker is dropped on one lane. Two instances, one with auto-realignment and one without, receive the same stimulus, which separates the two recovery paths.
- Held relink, held and pulsed loss of ready, and a stalled lane that overflows its neighbours' FIFOs each exercise one way back to idle.

// File: rtl/lane_deskew.sv
module lane_deskew #(
  parameter int LANES        = 4,
  parameter int DW           = 16,
  parameter int DEPTH        = 8,
  parameter int AUTO_REALIGN = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES-1:0]    in_vld,
  input  logic [LANES-1:0]    in_mark,
  input  logic [LANES-1:0]    lane_rdy,
  input  logic                relink,
  output logic [LANES*DW-1:0] out_data,
  output logic                out_vld,
  output logic                aligned,
  output logic                err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ALIGNED, S_ERROR} state_t;

  state_t st, nxt;
  logic [LANES-1:0] ne, hm, full, pop, push, ovf;
  logic all_rdy, run, acq, misal;

  assign all_rdy = &lane_rdy;
  assign run     = (st == S_WAIT) || (st == S_ALIGNED);
  assign push    = in_vld & {LANES{run}};
  assign acq     = (st == S_WAIT) && (&ne) && (&hm);
  assign misal   = (st == S_ALIGNED) && (&ne) && (|hm) && !(&hm);
  assign out_vld = (st == S_ALIGNED) && (&ne) && !misal;
  assign aligned = (st == S_ALIGNED);
  assign err     = (st == S_ERROR);

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr;

    assign wr      = push[g] && !ovf[g];
    assign ne[g]   = (cnt != '0);
    assign full[g] = (cnt == CW'(DEPTH));
    assign hm[g]   = mem[rp][DW];
    assign out_data[g*DW +: DW] = mem[rp][DW-1:0];
    assign pop[g]  = ((st == S_WAIT) && ne[g] && !hm[g]) || out_vld;
    assign ovf[g]  = push[g] && full[g] && !pop[g];

    always_ff @(posedge clk)
      if (wr) mem[wp] <= {in_mark[g], in_data[g*DW +: DW]};

    always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (wr)     wp <= step_ptr(wp);
        if (pop[g]) rp <= step_ptr(rp);
        cnt <= cnt + CW'(wr) - CW'(pop[g]);
      end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
  end

  always_comb begin
    nxt = st;
    if (relink || !all_rdy) nxt = S_IDLE;
    else begin
      case (st)
        S_IDLE:    nxt = S_WAIT;
        S_WAIT:    if (|ovf) nxt = S_IDLE;
                   else if (acq) nxt = S_ALIGNED;
        S_ALIGNED: if (|ovf) nxt = S_IDLE;
                   else if (misal) nxt = (AUTO_REALIGN != 0) ? S_IDLE : S_ERROR;
        S_ERROR:   nxt = S_ERROR;
        default:   nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;

  // R8
  relink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (relink || !all_rdy) |=> (!aligned && !out_vld));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && relink) |=> (st == S_IDLE));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !relink && all_rdy) |=> err);

  // R6
  misal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misal && !relink && all_rdy && !(|ovf)) |=>
      (!aligned && (err == (AUTO_REALIGN == 0))));
endmodule

// File: tb/test_lane_deskew.sv
module test_lane_deskew;
  localparam int L = 3, W = 8, D = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [L*W-1:0] in_data;
  logic [L-1:0]   in_vld, in_mark, lane_rdy;
  logic           relink;
  logic [L*W-1:0] od_a, od_b;
  logic           ov_a, ov_b, al_a, al_b, er_a, er_b;

  lane_deskew #(.LANES(L), .DW(W), .DEPTH(D), .AUTO_REALIGN(1)) i_lane_deskew (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_vld(in_vld), .in_mark(in_mark),
    .lane_rdy(lane_rdy), .relink(relink), .out_data(od_a), .out_vld(ov_a),
    .aligned(al_a), .err(er_a));

  lane_deskew #(.LANES(L), .DW(W), .DEPTH(D), .AUTO_REALIGN(0)) i_lane_deskew_noauto (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_vld(in_vld), .in_mark(in_mark),
    .lane_rdy(lane_rdy), .relink(relink), .out_data(od_b), .out_vld(ov_b),
    .aligned(al_b), .err(er_b));

  int checks = 0, errors = 0, wd = 0;
  int cyc = 0;
  int sk [L];
  bit hold = 1'b1;
  int drop_lane = -1, drop_v = -1, stall_lane = -1;
  bit hp_a = 1'b0, hp_b = 1'b0;
  int pv_a = 0, pv_b = 0;

  always @(posedge clk) begin
    wd++;
    if (wd == 190000) begin
      errors++; checks++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", wd, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon(input logic ov, input logic al, input logic [L*W-1:0] od,
                     inout bit hp, inout int pv);
    int low;
    low = int'(od[4:0]);
    if (ov) begin
      chk(al == 1'b1, "R5 out_vld only while aligned", int'(al), 1);
      for (int i = 0; i < L; i++)
        chk(int'(od[i*W+5 +: 3]) == i && od[i*W +: 5] == od[4:0],
            "R3 lanes carry one stream position", int'(od[i*W +: W]), (i << 5) | low);
      if (!hp) chk(low == 0, "R3 first forwarded word is the marker", low, 0);
      else     chk(low == ((pv + 1) & 31), "R4 words in order", low, (pv + 1) & 31);
      hp = 1'b1;
      pv = low;
    end
    if (!al) hp = 1'b0;
  endtask

  task automatic step();
    int v;
    @(negedge clk);
    mon(ov_a, al_a, od_a, hp_a, pv_a);
    mon(ov_b, al_b, od_b, hp_b, pv_b);
    if (hold) cyc = 0; else cyc++;
    for (int i = 0; i < L; i++) begin
      v = cyc - sk[i];
      in_vld[i] = !hold && v >= 1 && i != stall_lane;
      in_data[i*W +: W] = {3'(i), 5'(v)};
      in_mark[i] = in_vld[i] && (v % 32 == 0) && !(i == drop_lane && v == drop_v);
    end
  endtask

  task automatic restart(input int a, input int b, input int c);
    hold = 1'b1; relink = 1'b1; lane_rdy = '1;
    drop_lane = -1; drop_v = -1; stall_lane = -1;
    repeat (3) step();
    sk[0] = a; sk[1] = b; sk[2] = c;
    relink = 1'b0; hold = 1'b0;
  endtask

  task automatic acquire(input string tag);
    int n = 0;
    while (!(al_a && al_b) && n < 80) begin step(); n++; end
    chk(al_a && al_b, tag, int'(al_a) + int'(al_b), 2);
  endtask

  initial begin
    int n;
    bit seen;
    in_data = '0; in_vld = '0; in_mark = '0; lane_rdy = '1; relink = 1'b0;
    sk[0] = 0; sk[1] = 0; sk[2] = 0;
    repeat (4) step();
    rst_n = 1'b1;
    step();
    chk(!al_a && !al_b, "R1 aligned low after reset", int'(al_a) + int'(al_b), 0);
    chk(!er_a && !er_b, "R1 err low after reset", int'(er_a) + int'(er_b), 0);
    chk(!ov_a && !ov_b, "R1 out_vld low after reset", int'(ov_a) + int'(ov_b), 0);

    // R3 / R4: sweep of every skew combination up to DEPTH-2
    for (int a = 0; a <= D - 2; a++)
      for (int b = 0; b <= D - 2; b++)
        for (int c = 0; c <= D - 2; c++) begin
          restart(a, b, c);
          acquire("R3 acquisition under skew");
          repeat (40) step();
          chk(al_a && al_b && !er_a && !er_b, "R4 alignment kept on clean stream",
              int'(al_a) + int'(al_b), 2);
        end

    // R2: relink held, then one lane not ready
    restart(0, 0, 0);
    relink = 1'b1;
    seen = 1'b0;
    repeat (80) begin step(); if (al_a || al_b) seen = 1'b1; end
    chk(!seen, "R2 no alignment while relink held", int'(seen), 0);
    relink = 1'b0;
    lane_rdy = 3'b101;
    seen = 1'b0;
    repeat (80) begin step(); if (al_a || al_b) seen = 1'b1; end
    chk(!seen, "R2 no alignment while a lane is not ready", int'(seen), 0);
    lane_rdy = '1;
    acquire("R2 leaves idle once all ready");

    // R6 / R7: one marker missing on lane 1
    restart(0, 3, 5);
    acquire("R3 acquisition before marker drop");
    drop_lane = 1; drop_v = 64;
    n = 0;
    while (al_a && n < 80) begin step(); n++; end
    chk(!al_a, "R6 missing marker drops aligned", int'(al_a), 0);
    chk(!er_a, "R6 no error with auto realign", int'(er_a), 0);
    chk(er_b && !al_b, "R7 missing marker raises err", int'(er_b), 1);
    n = 0;
    while (!al_a && n < 80) begin step(); n++; end
    chk(al_a && !er_a, "R6 realigns without relink", int'(al_a), 1);
    chk(er_b && !al_b && !ov_b, "R7 error held until relink", int'(er_b), 1);
    restart(0, 3, 5);
    acquire("R7 relink restores alignment");
    chk(!er_b, "R7 relink clears err", int'(er_b), 0);

    // R8: ready loss and relink while aligned
    restart(2, 0, 4);
    acquire("R3 acquisition before ready loss");
    repeat (5) step();
    lane_rdy[2] = 1'b0;
    step();
    lane_rdy = '1;
    chk(!al_a && !al_b && !ov_a && !ov_b, "R8 ready loss drops aligned",
        int'(al_a) + int'(al_b), 0);
    restart(2, 0, 4);
    acquire("R8 flushed FIFOs realign from a marker");
    repeat (3) step();
    relink = 1'b1;
    step();
    relink = 1'b0;
    chk(!al_a && !al_b && !ov_a && !ov_b, "R8 relink drops aligned",
        int'(al_a) + int'(al_b), 0);

    // R9: stalled lane overflows the others
    restart(0, 0, 0);
    acquire("R3 acquisition before stall");
    repeat (5) step();
    stall_lane = 0;
    n = 0;
    while (al_a && n < 30) begin step(); n++; end
    chk(!al_a && n >= 6 && n <= 14, "R9 overflow returns to idle", n, 10);
    chk(!er_b && !al_b, "R9 overflow gives no error", int'(er_b), 0);
    stall_lane = -1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule